// File: doc/BRIEF.md
# Bank-Switched Host Register Window

This block lets a host reach a larger register set through a fixed window of sixteen I/O offsets. The set is split into three banks of sixteen registers each. A two-bit bank pointer, held in a command register, picks which bank the window currently shows. Host reads and writes at a 4-bit offset go to the matching register of the selected bank.

The command register answers at offset 0 in every bank, so software can always switch banks again, whichever bank is showing. Its pointer field is stored. Its other bits are not stored: writing them produces a one-cycle command strobe for the rest of the controller.

The other offsets of each bank are one of three kinds, set by two mask parameters. Storage registers are written by the host and driven out flat to the controller. Status registers are read-only and are taken from flat inputs. Unimplemented offsets read as zero and ignore writes.

Top module: `regwin_top`

## Requirements
- R1: A synchronous active-high reset clears the bank pointer to bank 0, every storage register to zero, `rd_data` to zero and `cmd_stb` to zero.
- R2: A write at offsets 1 to 7 updates only that register in the selected bank. The new value appears on `cfg_q` right after the write's clock edge. Register (bank b, offset o) sits at `cfg_q[(b*16+o)*8 +: 8]`, and the same register in the other banks keeps its value.
- R3: A read (`rd_en` high) of a storage register in the selected bank returns its value on `rd_data` after one clock edge. `rd_data` holds its value while `rd_en` is low.
- R4: Offset 0 is the command register in every bank. Writing it with `wr_data[7:6]` equal to 0, 1 or 2 selects that bank, shown on `bank_sel` after the edge. Reading it returns the pointer in bits [7:6] and zero in bits [5:0].
- R5: Writing offset 0 with `wr_data[7:6]` = 3, a reserved value, leaves the selected bank unchanged.
- R6: A write to offset 0 drives `wr_data[5:0]` onto `cmd_stb` for exactly the one cycle after the write edge. These bits are not stored and read back as zero.
- R7: Offsets 8 to 11 are read-only status. A read returns `sts_i` at the same flat position as R2. Writes to these offsets change neither `cfg_q` nor later reads.
- R8: Offsets 12 to 15 are unimplemented. Reads return zero and writes change nothing.
- R9: A read and a write at the same offset in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Offset inside the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| bank_sel | output | 2 | Currently selected bank |
| cmd_stb | output | 6 | One-cycle command strobes |
| cfg_q | output | 384 | Flat storage registers of all banks |
| sts_i | input | 384 | Flat status inputs of all banks |

## Verification
Every result of this block is due one clock edge after its stimulus:
- read data,
- the new bank pointer,
- storage contents,
- the command strobe.

The bench drives its inputs on the falling edge and samples on the next falling edge, half a cycle after the edge that produces the result. The strobe is sampled a second time one cycle later to show that it is gone. Reads of offsets that must not change are made as separate transactions after the write that might have changed them.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Kind of register an offset resolves to
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CMD  = 2'd1,
    ACC_RW   = 2'd2,
    ACC_RO   = 2'd3
  } acc_e;

  // The command offset wins over both masks; storage wins over status
  function automatic acc_e classify(input logic is_cmd, input logic rw_bit,
                                    input logic ro_bit);
    if (is_cmd)      return ACC_CMD;
    else if (rw_bit) return ACC_RW;
    else if (ro_bit) return ACC_RO;
    else             return ACC_NONE;
  endfunction

endpackage

// File: rtl/regwin_cmd.sv
module regwin_cmd #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 2,
  parameter int NUM_BANKS = 3,
  parameter int CMD_OFF   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  bank_q,
  output logic [DATA_W-PTR_W-1:0] stb_q
);
  localparam int STB_W = DATA_W - PTR_W;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFF);
  localparam logic [PTR_W-1:0]  LAST_BANK = PTR_W'(NUM_BANKS - 1);

  logic             cmd_hit;
  logic [PTR_W-1:0] new_ptr;
  logic             ptr_ok;

  assign cmd_hit = wr_en && (addr == CMD_A);
  assign new_ptr = wr_data[DATA_W-1 -: PTR_W];
  assign ptr_ok  = (new_ptr <= LAST_BANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      stb_q  <= '0;
    end else begin
      stb_q <= cmd_hit ? wr_data[STB_W-1:0] : '0;
      if (cmd_hit && ptr_ok)
        bank_q <= new_ptr;
    end
  end

  // R4: a legal pointer write selects that bank on the next cycle
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && ptr_ok) |=> (bank_q == $past(new_ptr)));

  // R5: a reserved pointer leaves the selection as it was
  p_reserved_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !ptr_ok) |=> $stable(bank_q));

  // R5: the selection never reaches a bank that does not exist
  p_bank_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (bank_q <= LAST_BANK));

  // R6: the strobe is low in any cycle not preceded by a command write
  p_stb_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_hit) |=> (stb_q == '0));

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PTR_W   = 2,
  parameter int BANK_ID = 0,
  parameter logic [(2**ADDR_W)-1:0] RW_BITS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  bank_sel,
  output logic [(2**ADDR_W)*DATA_W-1:0] regs_q
);
  localparam int REGS = 2**ADDR_W;
  localparam logic [PTR_W-1:0] MY_ID = PTR_W'(BANK_ID);

  logic bank_we;
  assign bank_we = wr_en && (bank_sel == MY_ID);

  for (genvar o = 0; o < REGS; o++) begin : g_reg
    if (RW_BITS[o]) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (bank_we && (addr == ADDR_W'(o)))
          q <= wr_data;
      end
      assign regs_q[o*DATA_W +: DATA_W] = q;
    end else begin : g_empty
      assign regs_q[o*DATA_W +: DATA_W] = '0;
    end
  end

  // R2: a write aimed at another bank leaves this bank untouched
  p_other_bank_r2: assert property (@(posedge clk) disable iff (rst)
    (bank_sel != MY_ID) |=> $stable(regs_q));

  // R2: with no write pending, nothing in the bank moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(regs_q));

endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import regwin_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 2,
  parameter int NUM_BANKS = 3,
  parameter int CMD_OFF   = 0,
  parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] RW_MASK = '0,
  parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTR_W-1:0]  bank_sel,
  input  logic [NUM_BANKS*(2**ADDR_W)*DATA_W-1:0] cfg_all,
  input  logic [NUM_BANKS*(2**ADDR_W)*DATA_W-1:0] sts_all,
  output logic [DATA_W-1:0] rd_data
);
  localparam int REGS  = 2**ADDR_W;
  localparam int TOT   = NUM_BANKS * REGS;
  localparam int IDX_W = PTR_W + ADDR_W;
  localparam int PAD   = 2**IDX_W;
  localparam int STB_W = DATA_W - PTR_W;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFF);
  localparam logic [PAD-1:0] RW_PAD = PAD'(RW_MASK);
  localparam logic [PAD-1:0] RO_PAD = PAD'(RO_MASK);

  logic [PAD*DATA_W-1:0] cfg_pad;
  logic [PAD*DATA_W-1:0] sts_pad;
  logic [IDX_W-1:0]      idx;
  acc_e                  kind;
  logic [DATA_W-1:0]     rd_next;

  assign cfg_pad = {{((PAD-TOT)*DATA_W){1'b0}}, cfg_all};
  assign sts_pad = {{((PAD-TOT)*DATA_W){1'b0}}, sts_all};
  assign idx     = {bank_sel, addr};
  assign kind    = classify(addr == CMD_A, RW_PAD[idx], RO_PAD[idx]);

  always_comb begin
    unique case (kind)
      ACC_CMD:  rd_next = {bank_sel, {STB_W{1'b0}}};
      ACC_RW:   rd_next = cfg_pad[idx*DATA_W +: DATA_W];
      ACC_RO:   rd_next = sts_pad[idx*DATA_W +: DATA_W];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_next;
  end

  // R3: read data holds between reads
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> $stable(rd_data));

  // R4: a command read shows the pointer and clears the strobe field
  p_cmd_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CMD_A) |=>
      (rd_data[STB_W-1:0] == '0) && (rd_data[DATA_W-1 -: PTR_W] == $past(bank_sel)));

  // R8: an unimplemented offset reads as zero
  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == ACC_NONE) |=> (rd_data == '0));

endmodule

// File: rtl/regwin_top.sv
module regwin_top #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 2,
  parameter int NUM_BANKS = 3,
  parameter int CMD_OFF   = 0,
  parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] RW_MASK = 48'h00FE_00FE_00FE,
  parameter logic [NUM_BANKS*(2**ADDR_W)-1:0] RO_MASK = 48'h0F00_0F00_0F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  bank_sel,
  output logic [DATA_W-PTR_W-1:0] cmd_stb,
  output logic [NUM_BANKS*(2**ADDR_W)*DATA_W-1:0] cfg_q,
  input  logic [NUM_BANKS*(2**ADDR_W)*DATA_W-1:0] sts_i
);
  localparam int REGS   = 2**ADDR_W;
  localparam int BANK_W = REGS * DATA_W;

  regwin_cmd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
    .NUM_BANKS(NUM_BANKS), .CMD_OFF(CMD_OFF)
  ) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .bank_q(bank_sel), .stb_q(cmd_stb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    regwin_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .BANK_ID(b),
      .RW_BITS(RW_MASK[b*REGS +: REGS] & ~(REGS'(1) << CMD_OFF))
    ) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .bank_sel(bank_sel), .regs_q(cfg_q[b*BANK_W +: BANK_W])
    );
  end

  regwin_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .NUM_BANKS(NUM_BANKS),
    .CMD_OFF(CMD_OFF), .RW_MASK(RW_MASK), .RO_MASK(RO_MASK)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .bank_sel(bank_sel),
    .cfg_all(cfg_q), .sts_all(sts_i), .rd_data(rd_data)
  );

  // R1: the cycle after reset shows bank 0, idle strobes and empty read data
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (bank_sel == '0) && (cmd_stb == '0) && (rd_data == '0) && (cfg_q == '0));

endmodule

// File: tb/sim_regwin_top.sv
module sim_regwin_top;
  localparam int DW = 8;
  localparam int NB = 3;
  localparam int NR = 16;
  localparam int FW = NB * NR * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [1:0]    bank_sel;
  logic [5:0]    cmd_stb;
  logic [FW-1:0] cfg_q;
  logic [FW-1:0] sts_i;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  regwin_top u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .bank_sel(bank_sel), .cmd_stb(cmd_stb),
    .cfg_q(cfg_q), .sts_i(sts_i)
  );

  function automatic logic [7:0] sts_val(input int b, input int o);
    return {2'b10, 2'(b), 4'(o)};
  endfunction

  initial begin
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < NR; o++)
        sts_i[(b*NR+o)*DW +: DW] = sts_val(b, o);
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] cfg_at(input int b, input int o);
    return cfg_q[(b*NR+o)*DW +: DW];
  endfunction

  // {write, addr, data, expected read}
  localparam logic [20:0] VEC [18] = '{
    {1'b1, 4'd1,  8'h11, 8'h00},  // bank 0 store
    {1'b1, 4'd7,  8'h77, 8'h00},
    {1'b0, 4'd1,  8'h00, 8'h11},
    {1'b0, 4'd7,  8'h00, 8'h77},
    {1'b1, 4'd0,  8'h40, 8'h00},  // select bank 1
    {1'b0, 4'd1,  8'h00, 8'h00},
    {1'b1, 4'd1,  8'hA1, 8'h00},
    {1'b0, 4'd1,  8'h00, 8'hA1},
    {1'b0, 4'd0,  8'h00, 8'h40},
    {1'b1, 4'd0,  8'h80, 8'h00},  // select bank 2
    {1'b1, 4'd3,  8'hC3, 8'h00},
    {1'b0, 4'd3,  8'h00, 8'hC3},
    {1'b0, 4'd1,  8'h00, 8'h00},
    {1'b1, 4'd0,  8'hC0, 8'h00},  // reserved pointer
    {1'b0, 4'd0,  8'h00, 8'h80},
    {1'b1, 4'd0,  8'h00, 8'h00},  // back to bank 0
    {1'b0, 4'd1,  8'h00, 8'h11},
    {1'b0, 4'd12, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 bank_sel", {6'd0, bank_sel}, 8'h00);
    check("R1 cmd_stb", {2'd0, cmd_stb}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 cfg_q zero", {7'd0, |cfg_q}, 8'h00);

    // Table walk: R3 reads, R4 pointer, R5 reserved, R8 unimplemented
    for (int i = 0; i < 18; i++) begin
      if (VEC[i][20]) begin
        do_write(VEC[i][19:16], VEC[i][15:8]);
      end else begin
        do_read(VEC[i][19:16], r);
        check($sformatf("R3 table vector %0d", i), r, VEC[i][7:0]);
      end
    end

    // R2 storage placement and bank isolation
    check("R2 bank0 off1", cfg_at(0, 1), 8'h11);
    check("R2 bank0 off7", cfg_at(0, 7), 8'h77);
    check("R2 bank1 off1", cfg_at(1, 1), 8'hA1);
    check("R2 bank2 off1", cfg_at(2, 1), 8'h00);
    check("R2 bank2 off3", cfg_at(2, 3), 8'hC3);
    check("R4 bank_sel", {6'd0, bank_sel}, 8'h00);

    // R6 command strobe lasts one cycle and is not stored
    @(negedge clk);
    addr = 4'd0; wr_data = 8'h45; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 strobe high", {2'd0, cmd_stb}, 8'h05);
    check("R4 select via strobe write", {6'd0, bank_sel}, 8'h01);
    @(negedge clk);
    check("R6 strobe gone", {2'd0, cmd_stb}, 8'h00);
    do_read(4'd0, r);
    check("R6 strobe bits read zero", r, 8'h40);

    // R5 reserved pointer while in bank 1
    do_write(4'd0, 8'hC0);
    check("R5 bank kept", {6'd0, bank_sel}, 8'h01);

    // R7 status read-only
    do_read(4'd9, r);
    check("R7 status read", r, sts_val(1, 9));
    do_write(4'd9, 8'hFF);
    do_read(4'd9, r);
    check("R7 write ignored", r, sts_val(1, 9));
    check("R7 cfg unchanged", cfg_at(1, 9), 8'h00);

    // R8 unimplemented offsets ignore writes
    do_write(4'd13, 8'hEE);
    do_read(4'd13, r);
    check("R8 read zero", r, 8'h00);
    check("R8 cfg unchanged", cfg_at(1, 13), 8'h00);

    // R9 read and write in the same cycle
    do_write(4'd2, 8'h22);
    @(negedge clk);
    addr = 4'd2; wr_data = 8'h33; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 old value", rd_data, 8'h22);
    do_read(4'd2, r);
    check("R9 new value", r, 8'h33);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset bank", {6'd0, bank_sel}, 8'h00);
    check("R1 reset cfg", {7'd0, |cfg_q}, 8'h00);
    check("R1 reset rd_data", rd_data, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule